// File: doc/BRIEF.md
# ATA PIO Timing Parameter Calculator

This block turns the nanosecond timing needs of a two-drive parallel ATA channel into bus clock counts. It then packs those counts into the byte values that a channel timing controller expects. Software or a sequencer supplies the bus clock frequency in MHz and a PIO mode for each drive, with a flag for each drive that says whether it is fitted. A single-cycle start strobe begins the calculation. The unit holds an internal table of standard PIO 0 to 3 timings, giving the address setup, active pulse and full cycle time in ns for each mode. It converts each of the three phases of each drive to clocks, rounding up.

The conversion is ceil(t × f / 1000), computed as (t × f + 999) / 1000. The divide by 1000 runs on a restoring divider that produces one quotient bit per clock. The six conversions run one after another. Each result is held inside its own clamp window. The two drives then share one address-setup count, the larger of the two, and this count goes into a common miscellaneous byte together with a read-prefetch enable and a fixed ready-wait field. When the three output bytes are valid, `done` pulses for one clock.

Top module: `pio_timing_calc`

## Requirements
- R1: Each phase time t in ns converts to clocks as (t × f + 999) / 1000, with f the captured bus frequency in MHz. The table gives (setup, active, cycle) ns of (70,165,600) for mode 0, (50,125,383) for mode 1, (30,100,240) for mode 2 and (30,80,180) for mode 3.
- R2: The recovery time of a drive is its cycle time minus its setup time minus its active time, converted with the same rounding as R1.
- R3: Address setup is clamped to 1..4 clocks, the active pulse to 1..16 clocks and recovery to 2..17 clocks.
- R4: A drive whose present flag is 0 uses address 1, active 1 and recovery 2 clocks, whatever mode is requested for it.
- R5: The shared address-setup count is the larger of the two drives' address-setup counts.
- R6: `cycleDrv0` and `cycleDrv1` each hold (active − 1) in bits 7:4 and (recovery − 2) in bits 3:0.
- R7: `miscByte` holds `prefetchEn` in bit 6, (shared address − 1) in bits 5:4 and (ready wait − 2) in bits 2:1, with the ready wait fixed at 2. Bits 7, 3 and 0 are 0.
- R8: A requested mode above 3 is treated as mode 3.
- R9: `done` is high for exactly one clock per accepted start. The output bytes change only in that clock, and `busy` is high from the clock after an accepted start through the `done` clock.
- R10: The block samples its inputs only when it accepts a start. A start while `busy` is high, including in the `done` clock, is ignored and does not change the result.
- R11: After reset, all output bytes are 0 and `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation (accepted when idle) |
| busMhz | input | 8 | Bus clock frequency in MHz |
| modeDrv0 | input | 3 | Requested PIO mode, drive 0 |
| presentDrv0 | input | 1 | Drive 0 is fitted |
| modeDrv1 | input | 3 | Requested PIO mode, drive 1 |
| presentDrv1 | input | 1 | Drive 1 is fitted |
| prefetchEn | input | 1 | Read-prefetch enable copied to the misc byte |
| cycleDrv0 | output | 8 | Packed active/recovery byte, drive 0 |
| cycleDrv1 | output | 8 | Packed active/recovery byte, drive 1 |
| miscByte | output | 8 | Shared address setup, prefetch and ready-wait byte |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-clock pulse when the outputs are valid |

## Verification
A new start request can arrive in the same clock as the `done` pulse that ends the previous calculation. The bench raises `start` in exactly the clock where it sees `done` high, using different mode inputs. It then expects `busy` to stay low and no further `done` to appear, and it expects the output bytes to keep the values of the finished run. A second case sends a start in the middle of a run, with changed inputs. The result must still match the inputs captured by the first start.

// File: rtl/pio_calc_pkg.sv
package pio_calc_pkg;

  localparam int TIME_W  = 10;
  localparam int DIVISOR = 1000;
  localparam int ROUND   = DIVISOR - 1;
  localparam int REM_W   = $clog2(DIVISOR) + 1;
  localparam int NUM_OPS = 6;
  localparam int OP_W    = $clog2(NUM_OPS);

  typedef struct packed {
    logic [TIME_W-1:0] setupNs;
    logic [TIME_W-1:0] activeNs;
    logic [TIME_W-1:0] cycleNs;
  } modeTimes_t;

  typedef struct packed {
    logic            capture;
    logic            loadDiv;
    logic            stepDiv;
    logic            storeRes;
    logic            pack;
    logic [OP_W-1:0] opIdx;
  } calcStrobes_t;

  function automatic modeTimes_t lookupMode(input logic [1:0] m);
    modeTimes_t t;
    case (m)
      2'd0:    t = '{setupNs: TIME_W'(70), activeNs: TIME_W'(165), cycleNs: TIME_W'(600)};
      2'd1:    t = '{setupNs: TIME_W'(50), activeNs: TIME_W'(125), cycleNs: TIME_W'(383)};
      2'd2:    t = '{setupNs: TIME_W'(30), activeNs: TIME_W'(100), cycleNs: TIME_W'(240)};
      default: t = '{setupNs: TIME_W'(30), activeNs: TIME_W'(80),  cycleNs: TIME_W'(180)};
    endcase
    return t;
  endfunction

endpackage

// File: rtl/pio_calc_ctrl.sv
module pio_calc_ctrl
  import pio_calc_pkg::*;
#(
  parameter int DIV_STEPS = 18
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output calcStrobes_t stb,
  output logic         busy,
  output logic         done
);
  localparam int CNT_W = $clog2(DIV_STEPS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_DIV, ST_STORE, ST_PACK, ST_DONE
  } ctrlState_t;

  ctrlState_t        state;
  logic [CNT_W-1:0]  stepCnt;
  logic [OP_W-1:0]   opIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      opIdx   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_LOAD;
          opIdx <= '0;
        end
        ST_LOAD: begin
          state   <= ST_DIV;
          stepCnt <= '0;
        end
        ST_DIV: begin
          if (stepCnt == CNT_W'(DIV_STEPS - 1)) state <= ST_STORE;
          stepCnt <= stepCnt + 1'b1;
        end
        ST_STORE: begin
          if (opIdx == OP_W'(NUM_OPS - 1)) state <= ST_PACK;
          else begin
            opIdx <= opIdx + 1'b1;
            state <= ST_LOAD;
          end
        end
        ST_PACK: state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.capture  = (state == ST_IDLE) && start;
    stb.loadDiv  = (state == ST_LOAD);
    stb.stepDiv  = (state == ST_DIV);
    stb.storeRes = (state == ST_STORE);
    stb.pack     = (state == ST_PACK);
    stb.opIdx    = opIdx;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/pio_calc_dp.sv
module pio_calc_dp
  import pio_calc_pkg::*;
#(
  parameter int FREQ_W = 8,
  parameter int DRDY   = 2,
  localparam int PROD_W = TIME_W + FREQ_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  calcStrobes_t      stb,
  input  logic [FREQ_W-1:0] busMhz,
  input  logic [2:0]        modeDrv0,
  input  logic              presentDrv0,
  input  logic [2:0]        modeDrv1,
  input  logic              presentDrv1,
  input  logic              prefetchEn,
  output logic [7:0]        cycleDrv0,
  output logic [7:0]        cycleDrv1,
  output logic [7:0]        miscByte
);
  logic [FREQ_W-1:0] freqReg;
  logic [1:0]        modeReg [2];
  logic              presReg [2];
  logic              prefReg;

  logic [2:0] addrClk [2];
  logic [4:0] dataClk [2];
  logic [4:0] recClk  [2];

  logic [PROD_W-1:0] dividend;
  logic [REM_W-1:0]  remainder;
  logic [REM_W-1:0]  trial;
  logic              trialFits;

  logic              opDrive;
  logic [1:0]        opField;
  modeTimes_t        opTimes;
  logic [TIME_W-1:0] opNs;

  function automatic logic [1:0] limitMode(input logic [2:0] m);
    return (m > 3'd3) ? 2'd3 : m[1:0];
  endfunction

  // input capture on an accepted start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      freqReg    <= '0;
      modeReg[0] <= '0;
      modeReg[1] <= '0;
      presReg[0] <= 1'b0;
      presReg[1] <= 1'b0;
      prefReg    <= 1'b0;
    end else if (stb.capture) begin
      freqReg    <= busMhz;
      modeReg[0] <= limitMode(modeDrv0);
      modeReg[1] <= limitMode(modeDrv1);
      presReg[0] <= presentDrv0;
      presReg[1] <= presentDrv1;
      prefReg    <= prefetchEn;
    end
  end

  // operand selection: index = drive*3 + phase (setup, active, recovery)
  always_comb begin
    opDrive = (stb.opIdx >= OP_W'(3));
    opField = opDrive ? 2'(stb.opIdx - OP_W'(3)) : 2'(stb.opIdx);
    opTimes = lookupMode(modeReg[opDrive]);
    case (opField)
      2'd0:    opNs = opTimes.setupNs;
      2'd1:    opNs = opTimes.activeNs;
      default: opNs = opTimes.cycleNs - opTimes.setupNs - opTimes.activeNs;
    endcase
  end

  // restoring divider by DIVISOR, one quotient bit per step
  assign trial     = {remainder[REM_W-2:0], dividend[PROD_W-1]};
  assign trialFits = (trial >= REM_W'(DIVISOR));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dividend  <= '0;
      remainder <= '0;
    end else if (stb.loadDiv) begin
      dividend  <= PROD_W'(opNs) * PROD_W'(freqReg) + PROD_W'(ROUND);
      remainder <= '0;
    end else if (stb.stepDiv) begin
      remainder <= trialFits ? trial - REM_W'(DIVISOR) : trial;
      dividend  <= {dividend[PROD_W-2:0], trialFits};
    end
  end

  // clamp windows applied to the finished quotient
  logic [2:0] addrSat;
  logic [4:0] dataSat;
  logic [4:0] recSat;

  always_comb begin
    if (dividend < PROD_W'(1))      addrSat = 3'd1;
    else if (dividend > PROD_W'(4)) addrSat = 3'd4;
    else                            addrSat = 3'(dividend);

    if (dividend < PROD_W'(1))       dataSat = 5'd1;
    else if (dividend > PROD_W'(16)) dataSat = 5'd16;
    else                             dataSat = 5'(dividend);

    if (dividend < PROD_W'(2))       recSat = 5'd2;
    else if (dividend > PROD_W'(17)) recSat = 5'd17;
    else                             recSat = 5'(dividend);
  end

  for (genvar d = 0; d < 2; d++) begin : g_drive
    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrClk[d] <= 3'd1;
        dataClk[d] <= 5'd1;
        recClk[d]  <= 5'd2;
      end else if (stb.storeRes && (int'(opDrive) == d)) begin
        case (opField)
          2'd0:    addrClk[d] <= presReg[d] ? addrSat : 3'd1;
          2'd1:    dataClk[d] <= presReg[d] ? dataSat : 5'd1;
          default: recClk[d]  <= presReg[d] ? recSat  : 5'd2;
        endcase
      end
    end
  end

  // packing of the register bytes
  logic [2:0] sharedAddr;
  assign sharedAddr = (addrClk[0] > addrClk[1]) ? addrClk[0] : addrClk[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleDrv0 <= '0;
      cycleDrv1 <= '0;
      miscByte  <= '0;
    end else if (stb.pack) begin
      cycleDrv0 <= {4'(dataClk[0] - 5'd1), 4'(recClk[0] - 5'd2)};
      cycleDrv1 <= {4'(dataClk[1] - 5'd1), 4'(recClk[1] - 5'd2)};
      miscByte  <= {1'b0, prefReg, 2'(sharedAddr - 3'd1), 1'b0, 2'(DRDY - 2), 1'b0};
    end
  end

endmodule

// File: rtl/pio_timing_calc.sv
module pio_timing_calc
  import pio_calc_pkg::*;
#(
  parameter int FREQ_W = 8,
  parameter int DRDY   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [FREQ_W-1:0] busMhz,
  input  logic [2:0]        modeDrv0,
  input  logic              presentDrv0,
  input  logic [2:0]        modeDrv1,
  input  logic              presentDrv1,
  input  logic              prefetchEn,
  output logic [7:0]        cycleDrv0,
  output logic [7:0]        cycleDrv1,
  output logic [7:0]        miscByte,
  output logic              busy,
  output logic              done
);
  localparam int PROD_W = TIME_W + FREQ_W;

  calcStrobes_t stb;

  pio_calc_ctrl #(.DIV_STEPS(PROD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stb(stb), .busy(busy), .done(done)
  );

  pio_calc_dp #(.FREQ_W(FREQ_W), .DRDY(DRDY)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busMhz(busMhz),
    .modeDrv0(modeDrv0), .presentDrv0(presentDrv0),
    .modeDrv1(modeDrv1), .presentDrv1(presentDrv1),
    .prefetchEn(prefetchEn),
    .cycleDrv0(cycleDrv0), .cycleDrv1(cycleDrv1), .miscByte(miscByte)
  );

endmodule

// File: rtl/pio_calc_checker.sv
module pio_calc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic [7:0] cycleDrv0,
  input logic [7:0] cycleDrv1,
  input logic [7:0] miscByte,
  input logic       busy,
  input logic       done
);
  a_r9_done_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_done_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  a_r9_outputs_change_on_done: assert property (@(posedge clk) disable iff (!rstN)
    (cycleDrv0 != $past(cycleDrv0) || cycleDrv1 != $past(cycleDrv1) ||
     miscByte != $past(miscByte)) |-> done);

  a_r10_busy_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  a_r10_start_in_done_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> !busy);

  a_r7_misc_zero_bits: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (miscByte[7] == 1'b0 && miscByte[3] == 1'b0 && miscByte[0] == 1'b0));
endmodule

bind pio_timing_calc pio_calc_checker u_chk (
  .clk(clk), .rstN(rstN), .start(start),
  .cycleDrv0(cycleDrv0), .cycleDrv1(cycleDrv1), .miscByte(miscByte),
  .busy(busy), .done(done)
);

// File: tb/pio_timing_calc_test.sv
module pio_timing_calc_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] busMhz = '0;
  logic [2:0] modeDrv0 = '0, modeDrv1 = '0;
  logic       presentDrv0 = 1'b0, presentDrv1 = 1'b0, prefetchEn = 1'b0;
  logic [7:0] cycleDrv0, cycleDrv1, miscByte;
  logic       busy, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pio_timing_calc uut (
    .clk(clk), .rstN(rstN), .start(start), .busMhz(busMhz),
    .modeDrv0(modeDrv0), .presentDrv0(presentDrv0),
    .modeDrv1(modeDrv1), .presentDrv1(presentDrv1),
    .prefetchEn(prefetchEn),
    .cycleDrv0(cycleDrv0), .cycleDrv1(cycleDrv1), .miscByte(miscByte),
    .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
    end
  endtask

  function automatic int toClk(input int t, input int f);
    return (t * f + 999) / 1000;
  endfunction

  function automatic int clampI(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  // expected clocks for one drive: {addr, data, rec}
  task automatic refDrive(input int f, input int m, input bit p,
                          output int a, output int d, output int r);
    int s, ac, cy, mm;
    if (!p) begin a = 1; d = 1; r = 2; return; end
    mm = (m > 3) ? 3 : m;
    case (mm)
      0: begin s = 70; ac = 165; cy = 600; end
      1: begin s = 50; ac = 125; cy = 383; end
      2: begin s = 30; ac = 100; cy = 240; end
      default: begin s = 30; ac = 80; cy = 180; end
    endcase
    a = clampI(toClk(s, f), 1, 4);
    d = clampI(toClk(ac, f), 1, 16);
    r = clampI(toClk(cy - s - ac, f), 2, 17);
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin ok = 1'b1; return; end
      @(negedge clk);
    end
  endtask

  task automatic expectResult(input string req, input int f, input int m0, input bit p0,
                              input int m1, input bit p1, input bit pf);
    int a0, d0, r0, a1, d1, r1, ax;
    refDrive(f, m0, p0, a0, d0, r0);
    refDrive(f, m1, p1, a1, d1, r1);
    ax = (a0 > a1) ? a0 : a1;
    check({req, " cycle0"}, cycleDrv0, ((d0 - 1) << 4) | (r0 - 2));
    check({req, " cycle1"}, cycleDrv1, ((d1 - 1) << 4) | (r1 - 2));
    check({req, " misc"},   miscByte, (int'(pf) << 6) | ((ax - 1) << 4));
  endtask

  task automatic runCase(input string req, input int f, input int m0, input bit p0,
                         input int m1, input bit p1, input bit pf);
    bit ok;
    busMhz = 8'(f); modeDrv0 = 3'(m0); presentDrv0 = p0;
    modeDrv1 = 3'(m1); presentDrv1 = p1; prefetchEn = pf;
    pulseStart();
    waitDone(ok);
    check({req, " done seen"}, int'(ok), 1);
    expectResult(req, f, m0, p0, m1, p1, pf);
    @(negedge clk);
    check({req, " R9 done one clock"}, int'(done), 0);
  endtask

  task automatic testReset();
    check("R11 cycle0 reset", cycleDrv0, 0);
    check("R11 cycle1 reset", cycleDrv1, 0);
    check("R11 misc reset", miscByte, 0);
    check("R11 busy reset", int'(busy), 0);
    check("R11 done reset", int'(done), 0);
  endtask

  task automatic testBusyStart();
    bit ok;
    busMhz = 8'd33; modeDrv0 = 3'd0; presentDrv0 = 1'b1;
    modeDrv1 = 3'd2; presentDrv1 = 1'b1; prefetchEn = 1'b1;
    pulseStart();
    check("R9 busy after start", int'(busy), 1);
    repeat (10) @(negedge clk);
    busMhz = 8'd200; modeDrv0 = 3'd3; presentDrv0 = 1'b0; prefetchEn = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    waitDone(ok);
    check("R10 done after busy start", int'(ok), 1);
    expectResult("R10 mid-run start ignored", 33, 0, 1, 2, 1, 1);
    // start exactly in the done clock
    busMhz = 8'd5; modeDrv1 = 3'd0;
    start = 1'b1; @(negedge clk); start = 1'b0;
    check("R10 start in done ignored busy", int'(busy), 0);
    for (int i = 0; i < 30; i++) begin
      if (done || busy) begin
        check("R10 no run after done start", 1, 0);
        break;
      end
      @(negedge clk);
    end
    expectResult("R10 outputs kept", 33, 0, 1, 2, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    runCase("R1 R6 both mode0 33MHz", 33, 0, 1, 0, 1, 1);
    runCase("R2 R5 mixed modes 50MHz", 50, 1, 1, 3, 1, 0);
    runCase("R5 slave slower 66MHz", 66, 3, 1, 0, 1, 1);
    runCase("R3 upper clamps 255MHz", 255, 0, 1, 0, 1, 0);
    runCase("R3 lower clamps 1MHz", 1, 3, 1, 3, 1, 0);
    runCase("R4 drive1 absent", 40, 2, 1, 0, 0, 1);
    runCase("R4 both absent", 100, 0, 0, 1, 0, 0);
    runCase("R8 mode7 as mode3", 40, 7, 1, 5, 1, 1);
    runCase("R7 prefetch off 25MHz", 25, 2, 1, 1, 1, 0);
    testBusyStart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule